// File: doc/BRIEF.md
# Dual-Mode Infrared Serial Modulator

This block sits between a UART and an infrared optical front end. On the way out, it takes the UART's serial transmit bit and turns it into a line signal in which a logic zero shows up as light and a logic one as darkness. On the way in, it takes the raw infrared receive level and turns it back into a serial bit that the UART can sample. Each character starts with a zero start bit, and the data bits follow it.

Two physical encodings can be chosen at run time with a single select input:

- **Pulse mode.** A zero bit is one short pulse placed at the start of the bit period. This mode is meant for rates up to 115.2 kbps.
- **Carrier mode.** A zero bit is a square carrier, nominally 500 kHz, that lasts the whole bit period. This mode is meant for rates up to 19.2 kbaud.

The block does not count baud periods itself. It times pulses and bit boundaries from a 16x baud tick that the UART's baud generator supplies. It makes the carrier by dividing down the system clock.

Top module: `ir_dual_modem`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released with `enable` low, `ir_tx_out` is 0 and `uart_rxd` is 1.
- R2: In pulse mode (`ask_sel`=0), a zero bit drives `ir_tx_out` high for PULSE_TICKS (3) tick intervals, starting at the clock edge that samples the bit-start tick.
- R3: In pulse mode, a one bit keeps `ir_tx_out` low for the entire bit.
- R4: In carrier mode (`ask_sel`=1), a zero bit drives a square wave on `ir_tx_out`. The wave has a half period of CLK_HZ/(2*CARRIER_HZ) clocks, starts high at the bit-start edge, and restarts in that phase at every zero bit.
- R5: In carrier mode, a one bit keeps `ir_tx_out` low for the entire bit.
- R6: A bit boundary falls on a tick where `uart_txd` differs from the bit being sent. Otherwise it falls on every OVERSAMPLE-th (16th) tick, so back-to-back zero bits each get their own pulse or their own restarted carrier.
- R7: In pulse mode, a rising edge on `ir_rx_in` drives `uart_rxd` low 2 clocks after the input changes. `uart_rxd` stays low until the 17th tick after detection, and a new pulse restarts that count.
- R8: In carrier mode, any edge on `ir_rx_in` drives `uart_rxd` low 2 clocks after the input changes. `uart_rxd` returns high once WIN = ASK_WIN_PERIODS*2*half-period clocks pass with no edge.
- R9: `ask_sel` may change between characters, and the selected encoding then applies to both transmit and receive.
- R10: While `enable` is low, `ir_tx_out` stays 0 and `uart_rxd` stays 1 whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low forces idle outputs |
| ask_sel | input | 1 | 0 = pulse encoding, 1 = carrier encoding |
| baud16_tick | input | 1 | One-clock strobe at 16 times the baud rate |
| uart_txd | input | 1 | Serial transmit bit from the UART |
| ir_rx_in | input | 1 | Raw infrared receive level, 1 = light |
| ir_tx_out | output | 1 | Infrared transmit drive, 1 = light |
| uart_rxd | output | 1 | Recovered serial receive bit to the UART |

## Verification
The bench builds the block with a 2.5 MHz carrier at the 50 MHz clock, which gives a 10-clock half period and a 40-clock receive window, and with a tick every 8 clocks. With these values a 128-clock bit holds several whole carrier periods, so every clock of every bit can be compared against an arithmetic model. The bench sweeps a set of bytes, including 0x00 and 0xFF, through both encodings in both directions. It then repeats a frame with the block disabled. Runs of zeros show the per-bit pulse and the carrier restart. Zero-to-one transitions show the exact release points of both receivers.

// File: rtl/ir_dual_modem.sv
module ir_dual_modem #(
  parameter int CLK_HZ          = 50_000_000,
  parameter int CARRIER_HZ      = 500_000,
  parameter int OVERSAMPLE      = 16,
  parameter int PULSE_TICKS     = 3,
  parameter int ASK_WIN_PERIODS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic ask_sel,
  input  logic baud16_tick,
  input  logic uart_txd,
  input  logic ir_rx_in,
  output logic ir_tx_out,
  output logic uart_rxd
);

  localparam int HALF = CLK_HZ / (2 * CARRIER_HZ);
  localparam int WIN  = ASK_WIN_PERIODS * 2 * HALF;
  localparam int HOLD = OVERSAMPLE + 1;
  localparam int PW   = $clog2(OVERSAMPLE);
  localparam int CW   = $clog2(HALF + 1);
  localparam int WW   = $clog2(WIN + 1);
  localparam int HW   = $clog2(HOLD + 1);

  logic          tx_bit;
  logic [PW-1:0] tx_phase;
  logic [CW-1:0] car_cnt;
  logic          car;
  logic          bit_start;
  logic [2:0]    sync;
  logic          i_low, a_low;
  logic [HW-1:0] i_cnt;
  logic [WW-1:0] a_cnt;

  assign bit_start = baud16_tick &&
                     (uart_txd != tx_bit || tx_phase == PW'(OVERSAMPLE - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_bit   <= 1'b1;
      tx_phase <= '0;
    end else if (bit_start) begin
      tx_bit   <= uart_txd;
      tx_phase <= '0;
    end else if (baud16_tick) begin
      tx_phase <= tx_phase + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      car_cnt <= '0;
      car     <= 1'b0;
    end else if (bit_start && !uart_txd) begin
      car_cnt <= '0;
      car     <= 1'b1;
    end else if (car_cnt == CW'(HALF - 1)) begin
      car_cnt <= '0;
      car     <= ~car;
    end else begin
      car_cnt <= car_cnt + 1'b1;
    end
  end

  assign ir_tx_out = enable && !tx_bit &&
                     (ask_sel ? car : (tx_phase < PW'(PULSE_TICKS)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= '0;
    else        sync <= {sync[1:0], ir_rx_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_low <= 1'b0;
      i_cnt <= '0;
    end else if (!enable) begin
      i_low <= 1'b0;
      i_cnt <= '0;
    end else if (sync[1] && !sync[2]) begin
      i_low <= 1'b1;
      i_cnt <= '0;
    end else if (i_low && baud16_tick) begin
      if (i_cnt == HW'(HOLD - 1)) begin
        i_low <= 1'b0;
        i_cnt <= '0;
      end else begin
        i_cnt <= i_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_low <= 1'b0;
      a_cnt <= '0;
    end else if (!enable) begin
      a_low <= 1'b0;
      a_cnt <= '0;
    end else if (sync[1] != sync[2]) begin
      a_low <= 1'b1;
      a_cnt <= '0;
    end else if (a_low) begin
      if (a_cnt == WW'(WIN - 1)) begin
        a_low <= 1'b0;
        a_cnt <= '0;
      end else begin
        a_cnt <= a_cnt + 1'b1;
      end
    end
  end

  assign uart_rxd = ~(ask_sel ? a_low : i_low);

  p_phase_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (baud16_tick && uart_txd != tx_bit) |=> (tx_phase == '0 && tx_bit == $past(uart_txd)));

  p_pulse_at_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ir_tx_out) && !ask_sel && !$past(ask_sel) && $past(enable)) |-> tx_phase == '0);

  p_carrier_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (car_cnt != '0) |-> $stable(car));

  p_rx_idle_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enable) |-> uart_rxd);

  p_pulse_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(i_low) && $past(enable)) |-> ($past(i_cnt) == HW'(HOLD - 1) && $past(baud16_tick)));

  p_carrier_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(a_low) && $past(enable)) |-> $past(a_cnt) == WW'(WIN - 1));

endmodule

// File: tb/ir_dual_modem_bench.sv
module ir_dual_modem_bench;
  localparam int CLK_HZ = 50_000_000;
  localparam int CAR_HZ = 2_500_000;
  localparam int HALF   = CLK_HZ / (2 * CAR_HZ);
  localparam int TD     = 8;
  localparam int OVS    = 16;
  localparam int BITC   = TD * OVS;
  localparam int PULSE  = 3;
  localparam int WINP   = 2;
  localparam int WIN    = WINP * 2 * HALF;
  localparam int RXH    = 8;
  localparam int REL    = WIN + 2 - RXH;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, ask_sel = 1'b0;
  logic tick = 1'b0, txd = 1'b1, irin = 1'b0;
  logic ir_tx_out, uart_rxd;
  int   checks = 0, failures = 0;
  bit   done = 1'b0, prev_rx = 1'b1, prev_tx = 1'b1, fresh = 1'b0;

  always #10 clk = ~clk;

  ir_dual_modem #(.CLK_HZ(CLK_HZ), .CARRIER_HZ(CAR_HZ), .OVERSAMPLE(OVS),
                  .PULSE_TICKS(PULSE), .ASK_WIN_PERIODS(WINP)) u_ir_dual_modem (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ask_sel(ask_sel),
    .baud16_tick(tick), .uart_txd(txd), .ir_rx_in(irin),
    .ir_tx_out(ir_tx_out), .uart_rxd(uart_rxd));

  task automatic chk(input logic got, input logic exp, input string tag,
                     input string what, input int j);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s mode=%0d j=%0d actual=%0b expected=%0b",
               tag, what, ask_sel, j, got, exp);
    end
  endtask

  task automatic run_bit(input bit tb, input bit rb);
    for (int j = 0; j < BITC; j++) begin
      logic et, er;
      string tt, rt;
      @(negedge clk);
      tick = (j % TD == 0);
      if (j == 0) txd = tb;
      irin = ask_sel ? (!rb && ((j / RXH) % 2 == 0)) : (!rb && j < PULSE * TD);
      @(posedge clk);
      #5;
      if (!enable) begin
        et = 1'b0; er = 1'b1; tt = "R10"; rt = "R10";
      end else begin
        if (ask_sel) et = !tb && ((j / HALF) % 2 == 0);
        else         et = !tb && (j < PULSE * TD);
        if (!rb) er = (j < 2) ? prev_rx : 1'b0;
        else     er = (j < (ask_sel ? REL : TD)) ? prev_rx : 1'b1;
        if (fresh)              tt = "R9";
        else if (!tb && !prev_tx) tt = "R6";
        else if (ask_sel)       tt = tb ? "R5" : "R4";
        else                    tt = tb ? "R3" : "R2";
        rt = fresh ? "R9" : (ask_sel ? "R8" : "R7");
      end
      chk(ir_tx_out, et, tt, "ir_tx_out", j);
      chk(uart_rxd, er, rt, "uart_rxd", j);
    end
    prev_rx = rb;
    prev_tx = tb;
  endtask

  task automatic send_frame(input logic [7:0] d, input logic [7:0] r);
    run_bit(1'b0, 1'b0);
    for (int b = 0; b < 8; b++) run_bit(d[b], r[b]);
    run_bit(1'b1, 1'b1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    #5;
    chk(ir_tx_out, 1'b0, "R1", "ir_tx_out in reset", 0);
    chk(uart_rxd, 1'b1, "R1", "uart_rxd in reset", 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #5;
    chk(ir_tx_out, 1'b0, "R1", "ir_tx_out after reset", 0);
    chk(uart_rxd, 1'b1, "R1", "uart_rxd after reset", 0);
    @(negedge clk);
    enable = 1'b1;
    for (int m = 0; m < 2; m++) begin
      ask_sel = m[0];
      fresh = 1'b1;
      for (int k = 0; k < 3; k++) run_bit(1'b1, 1'b1);
      for (int i = 0; i < 14; i++) begin
        logic [7:0] d;
        d = (i == 12) ? 8'h00 : (i == 13) ? 8'hFF : 8'((i * 37 + 5) & 255);
        send_frame(d, d ^ 8'h5A);
        fresh = 1'b0;
      end
    end
    @(negedge clk);
    enable = 1'b0;
    for (int m = 0; m < 2; m++) begin
      ask_sel = m[0];
      send_frame(8'h00, 8'h00);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired checks=%0d", checks);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule